// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block turns the core clock into the timing ticks a SPI shift engine needs to toggle its serial clock. A prescale field chooses the divisor and the block produces a one-cycle tick on each serial-clock edge. `lead_o` marks the tick that opens a serial-clock period, and `tick_o` alone marks the tick in the middle of the period. The shift engine drives or samples data on these edges. The core clock stays the only clock, and the shift register sits outside this block.

The parameter `EXT_ENC` selects how the field is read. In the compact form (`EXT_ENC=0`) the field holds half the divisor, which gives even divisors from 4 to 30. In the extended form (`EXT_ENC=1`) the field holds a 4-bit mantissa and a 3-bit exponent, and their product gives divisors up to 1920. A combinational helper converts a requested divisor into the field value that gives the nearest serial-clock rate not above the request, or it flags that the request cannot be met.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While `en_i` is low, `tick_o` and `lead_o` stay low and the divider is held at its start. In the first cycle with `en_i` high, `tick_o` and `lead_o` are both high.
- R2: Compact form: the half divisor is field bits 3:0. Values 0 and 1 act as 2, and field bits 7:4 are ignored. Ticks come every half-divisor cycles.
- R3: Extended form: mantissa M = field[3:0] and exponent E = {field[7], field[6], field[4]} (E bit 0 is field bit 4). The divisor is M·2^E and field bit 5 is ignored.
- R4: Extended form: a mantissa of 0 or 1 acts as 2, so the divisor is never below 2. With M ≤ 2 and E = 0 a tick comes every core cycle.
- R5: With an odd divisor D, the mid-period tick comes floor(D/2) cycles after the period-start tick. The next period-start tick follows ceil(D/2) cycles later.
- R6: A field change while enabled takes effect only when the running period ends. The period in progress keeps its old mid tick and its old length.
- R7: `lead_o` is high only on the tick that opens a period, and the mid-period tick has `lead_o` low.
- R8: Extended helper: a request below 16 gives M = request and E = 0.
- R9: Extended helper: for a request of 16 or more, E is the MSB index minus 3. The request is rounded up to a multiple of 2^E, E is recomputed, and M = rounded >> E (e.g. 17→0x19, 31→0x48, 100→0x5D, 1920→0xDF).
- R10: Extended helper: when the exponent would exceed 7 (request above 1920), `calc_err_o` is high and `calc_field_o` is 0.
- R11: Compact helper: an odd request is rounded up to even, and a request below 4 becomes 4. The field is 0x10 plus half the divisor.
- R12: Compact helper: a rounded request above 30 sets `calc_err_o` high with `calc_field_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run the divider |
| prescale_i | input | FIELD_W | Prescale field in the selected form |
| req_div_i | input | REQ_W | Requested divisor for the helper |
| calc_field_o | output | FIELD_W | Helper result: field value for the request |
| calc_err_o | output | 1 | Helper: request cannot be met |
| tick_o | output | 1 | One-cycle tick per serial-clock edge |
| lead_o | output | 1 | Tick opens a new serial-clock period |

## Verification
The hardest case to reach from the ports is a field change that lands in the middle of a running period. The old divisor must still govern the remaining mid tick and the end of that period, and the new one must apply only from the next period on. The stimulus enables a divide-by-16 setting and waits three cycles past a period-start tick. It then writes a divide-by-4 field and measures the gaps that follow: 5 cycles, then 8, then 2 and 2, with `lead_o` checked on each tick. Odd divisors and the clamped mantissa values are also reached by writing fields that the helper would never produce.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

  localparam int FIELD_W = 8;

  // index of the most significant set bit, 0 when v is zero
  function automatic logic [4:0] msb_idx(input logic [15:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/presc_decode.sv
module presc_decode
  import spi_presc_pkg::*;
#(
  parameter bit EXT_ENC = 1'b1,
  parameter int DIV_W   = 11
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [DIV_W-1:0]   div_o
);

  generate
    if (EXT_ENC) begin : g_ext
      logic [3:0] mant;
      logic [2:0] expo;
      always_comb begin
        mant  = (field_i[3:0] < 4'd2) ? 4'd2 : field_i[3:0];
        expo  = {field_i[7], field_i[6], field_i[4]};
        div_o = DIV_W'(mant) << expo;
      end
    end else begin : g_cmp
      logic [3:0] half;
      always_comb begin
        half  = (field_i[3:0] < 4'd2) ? 4'd2 : field_i[3:0];
        div_o = DIV_W'(half) << 1;
      end
    end
  endgenerate

endmodule

// File: rtl/presc_encode.sv
module presc_encode
  import spi_presc_pkg::*;
#(
  parameter bit EXT_ENC = 1'b1,
  parameter int REQ_W   = 12
) (
  input  logic [REQ_W-1:0]   req_i,
  output logic [FIELD_W-1:0] field_o,
  output logic               err_o
);

  localparam int RW = REQ_W + 1;

  generate
    if (EXT_ENC) begin : g_ext
      logic [RW-1:0] r, msk, rnd;
      logic [4:0]    s0, s1;
      logic [3:0]    mant;
      logic [2:0]    expo;
      always_comb begin
        r    = {1'b0, req_i};
        s0   = '0;
        s1   = '0;
        msk  = '0;
        rnd  = r;
        mant = '0;
        expo = '0;
        err_o = 1'b0;
        if (r < RW'(16)) begin
          mant = r[3:0];
        end else begin
          s0   = msb_idx(16'(r)) - 5'd3;
          msk  = (RW'(1) << s0) - RW'(1);
          rnd  = (r + msk) & ~msk;
          s1   = msb_idx(16'(rnd)) - 5'd3;
          mant = 4'(rnd >> s1);
          expo = s1[2:0];
          err_o = (s1 > 5'd7);
        end
        field_o = err_o ? '0 : {expo[2], expo[1], 1'b0, expo[0], mant};
      end

      // R9: a granted field never gives a faster clock than requested
      always_comb begin
        if (!err_o) begin
          enc_no_faster_chk: assert ((RW'(field_o[3:0]) << {field_o[7], field_o[6], field_o[4]}) >= RW'(req_i));
        end
      end
    end else begin : g_cmp
      logic [RW-1:0] r;
      always_comb begin
        r = {1'b0, req_i} + RW'(req_i[0]);
        if (r < RW'(4)) r = RW'(4);
        err_o   = (r > RW'(30));
        field_o = err_o ? '0 : (FIELD_W'(8'h10) + FIELD_W'(r[4:1]));
      end
    end
  endgenerate

endmodule

// File: rtl/presc_tick.sv
module presc_tick #(
  parameter int DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             lead_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] half;
  logic             wrap, ld_div;

  always_comb begin
    half   = div_q >> 1;
    wrap   = (cnt_q == div_q - DIV_W'(1));
    ld_div = !en_i || wrap;
    if (!en_i || wrap) cnt_d = '0;
    else               cnt_d = cnt_q + DIV_W'(1);
    lead_o = en_i && (cnt_q == '0);
    tick_o = en_i && ((cnt_q == '0) || (cnt_q == half));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= DIV_W'(2);
    else if (ld_div) div_q <= div_i;
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  // R6
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(div_q));
  // R4
  div_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q >= DIV_W'(2));
  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && en_i && div_q >= DIV_W'(4)) |=> !tick_o);
  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_q);

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
  import spi_presc_pkg::*;
#(
  parameter bit EXT_ENC = 1'b1,
  parameter int REQ_W   = 12,
  parameter int DIV_W   = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] prescale_i,
  input  logic [REQ_W-1:0]   req_div_i,
  output logic [FIELD_W-1:0] calc_field_o,
  output logic               calc_err_o,
  output logic               tick_o,
  output logic               lead_o
);

  logic [DIV_W-1:0] div_dec;

  presc_decode #(.EXT_ENC(EXT_ENC), .DIV_W(DIV_W)) u_decode (
    .field_i (prescale_i),
    .div_o   (div_dec)
  );

  presc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (div_dec),
    .tick_o (tick_o),
    .lead_o (lead_o)
  );

  presc_encode #(.EXT_ENC(EXT_ENC), .REQ_W(REQ_W)) u_encode (
    .req_i   (req_div_i),
    .field_o (calc_field_o),
    .err_o   (calc_err_o)
  );

  // R7
  lead_is_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> tick_o);

endmodule

// File: tb/spi_sclk_prescaler_bench.sv
module spi_sclk_prescaler_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        en_e = 1'b0, en_l = 1'b0;
  logic [7:0]  pre_e = 8'h02, pre_l = 8'h12;
  logic [11:0] req_e = '0, req_l = '0;
  logic [7:0]  fld_e, fld_l;
  logic        err_e, err_l, tick_e, tick_l, lead_e, lead_l;

  int checks = 0;
  int errors = 0;

  spi_sclk_prescaler #(.EXT_ENC(1'b1)) u_spi_sclk_prescaler (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_e), .prescale_i(pre_e),
    .req_div_i(req_e), .calc_field_o(fld_e), .calc_err_o(err_e),
    .tick_o(tick_e), .lead_o(lead_e));

  spi_sclk_prescaler #(.EXT_ENC(1'b0)) u_spi_sclk_prescaler_cmp (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_l), .prescale_i(pre_l),
    .req_div_i(req_l), .calc_field_o(fld_l), .calc_err_o(err_l),
    .tick_o(tick_l), .lead_o(lead_l));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", rq, act, act, exp, exp);
    end
  endtask

  function automatic bit tk(input bit ext);
    return ext ? tick_e : tick_l;
  endfunction
  function automatic bit ld(input bit ext);
    return ext ? lead_e : lead_l;
  endfunction

  // cycles until the next tick, then check gap and lead flag
  task automatic gap(input bit ext, input int exp, input bit exp_lead, input string rq);
    int n = 0;
    do begin
      @(negedge clk); #1;
      n++;
    end while (!tk(ext) && n < 5000);
    chk(n == exp, rq, n, exp);
    chk(ld(ext) == exp_lead, {rq, " lead"}, int'(ld(ext)), int'(exp_lead));
  endtask

  // load a field while idle, then start and check the opening tick
  task automatic start(input bit ext, input logic [7:0] f, input string rq);
    @(negedge clk);
    if (ext) begin en_e = 1'b0; pre_e = f; end
    else     begin en_l = 1'b0; pre_l = f; end
    @(negedge clk);
    if (ext) en_e = 1'b1; else en_l = 1'b1;
    #1;
    chk(tk(ext) && ld(ext), {rq, " R1 first tick"}, int'(tk(ext)), 1);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk(!tick_e && !lead_e && !tick_l && !lead_l, "R1 idle", int'(tick_e | tick_l), 0);
    end
  endtask

  task automatic t_cmp_decode();
    start(1'b0, 8'h12, "R2");  gap(1'b0, 2, 1'b0, "R2 div4");  gap(1'b0, 2, 1'b1, "R7 div4");
    start(1'b0, 8'h1F, "R2");  gap(1'b0, 15, 1'b0, "R2 div30");
    start(1'b0, 8'h01, "R2");  gap(1'b0, 2, 1'b0, "R2 clamp");
    start(1'b0, 8'hEF, "R2");  gap(1'b0, 15, 1'b0, "R2 upper bits ignored");
    en_l = 1'b0;
  endtask

  task automatic t_ext_decode();
    start(1'b1, 8'h18, "R3");  gap(1'b1, 8, 1'b0, "R3 div16");  gap(1'b1, 8, 1'b1, "R3 div16 wrap");
    start(1'b1, 8'h5D, "R3");  gap(1'b1, 52, 1'b0, "R3 div104");
    start(1'b1, 8'h3A, "R3");  gap(1'b1, 10, 1'b0, "R3 bit5 ignored div20");
  endtask

  task automatic t_ext_min();
    start(1'b1, 8'h00, "R4");  gap(1'b1, 1, 1'b0, "R4 mant0");  gap(1'b1, 1, 1'b1, "R4 mant0");
    start(1'b1, 8'h01, "R4");  gap(1'b1, 1, 1'b0, "R4 mant1");
  endtask

  task automatic t_odd();
    start(1'b1, 8'h03, "R5");
    gap(1'b1, 1, 1'b0, "R5 div3 mid");  gap(1'b1, 2, 1'b1, "R5 div3 end");
    gap(1'b1, 1, 1'b0, "R5 div3 mid2");
  endtask

  task automatic t_midchange();
    start(1'b1, 8'h18, "R6");
    repeat (3) @(negedge clk);
    pre_e = 8'h04;
    gap(1'b1, 5, 1'b0, "R6 old mid tick");
    gap(1'b1, 8, 1'b1, "R6 old period end");
    gap(1'b1, 2, 1'b0, "R6 new mid");
    gap(1'b1, 2, 1'b1, "R6 new end");
    en_e = 1'b0;
  endtask

  task automatic hx(input logic [11:0] r, input int exp_f, input bit exp_err, input string rq);
    req_e = r; #1;
    chk(fld_e == 8'(exp_f), rq, int'(fld_e), exp_f);
    chk(err_e == exp_err, {rq, " err"}, int'(err_e), int'(exp_err));
  endtask

  task automatic hc(input logic [11:0] r, input int exp_f, input bit exp_err, input string rq);
    req_l = r; #1;
    chk(fld_l == 8'(exp_f), rq, int'(fld_l), exp_f);
    chk(err_l == exp_err, {rq, " err"}, int'(err_l), int'(exp_err));
  endtask

  task automatic t_helpers();
    hx(12'd10, 8'h0A, 1'b0, "R8 req10");
    hx(12'd15, 8'h0F, 1'b0, "R8 req15");
    hx(12'd16, 8'h18, 1'b0, "R9 req16");
    hx(12'd17, 8'h19, 1'b0, "R9 req17");
    hx(12'd31, 8'h48, 1'b0, "R9 req31");
    hx(12'd100, 8'h5D, 1'b0, "R9 req100");
    hx(12'd1920, 8'hDF, 1'b0, "R9 req1920");
    hx(12'd1921, 8'h00, 1'b1, "R10 req1921");
    hx(12'd4095, 8'h00, 1'b1, "R10 req4095");
    hc(12'd0, 8'h12, 1'b0, "R11 req0");
    hc(12'd3, 8'h12, 1'b0, "R11 req3");
    hc(12'd7, 8'h14, 1'b0, "R11 req7");
    hc(12'd30, 8'h1F, 1'b0, "R11 req30");
    hc(12'd29, 8'h1F, 1'b0, "R11 req29");
    hc(12'd31, 8'h00, 1'b1, "R12 req31");
    hc(12'd200, 8'h00, 1'b1, "R12 req200");
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!tick_e && !lead_e, "R1 reset", int'(tick_e), 0);
    rst_n = 1'b1;
    t_idle();
    t_cmp_decode();
    t_ext_decode();
    t_ext_min();
    t_odd();
    t_midchange();
    t_helpers();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule